// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This controller sits in the active-low chip-enable path between an address decoder and a static RAM. Its inputs are digital flags from external comparators: the supply is above the trip point, battery A or B is attached, battery B is the stronger one, the supply is below the selected battery, and the selected battery is low. When the supply flag drops, it write-protects the RAM by forcing the chip-enable output high. An access that is already running is allowed to finish first. When the supply returns, the output stays locked for a recovery interval. The interval is set in clock cycles from a clock-frequency parameter and a duration in microseconds.

After each recovery that follows a detected failure, the controller reports a weak battery by blocking one access. If the battery-low flag was set when the supply returned, the second chip-enable cycle after recovery is suppressed. Software can detect this by writing a value and reading it back. From reset, the block starts in a storage-seal state: both batteries stay disconnected until the supply is seen good for the first time. The block also drives a battery-enable output, a battery-select output and a backup-mode indication.

All flag inputs and the chip-enable input pass through two-flop synchronizers. The chip-enable output therefore follows the input two clock cycles later.

Top module: `pfce_gate`

## Requirements
- R1: After reset, `ce_out_n` is 1 and `write_protected` is 1, and `ce_out_n` stays 1 whatever `ce_in_n` does until the supply flag is first seen high.
- R2: While sealed, `batt_en` is 0 even with batteries attached. The seal ends permanently when `supply_ok` is first seen high, and `batt_en` is then 1 whenever a battery is present.
- R3: After `supply_ok` returns, `write_protected` falls exactly RECOV_CYCLES+3 clock edges after the input rose. The 3 covers two synchronizer stages and one state register. RECOV_CYCLES is CLK_HZ/1e6 times RECOV_US.
- R4: In normal operation, `ce_out_n` equals `ce_in_n` delayed by two clock cycles.
- R5: If the supply flag drops while the synchronized chip-enable is high, the controller becomes write-protected, and `ce_out_n` stays 1 for the rest of the failure.
- R6: If the supply flag drops while the synchronized chip-enable is low, `ce_out_n` keeps following it low until it returns high. Only then does the lock set.
- R7: If the supply flag drops again during recovery, the recovery is abandoned and the block stays write-protected.
- R8: If `batt_low` is set when recovery starts after a failure, the second falling edge of the synchronized chip-enable after recovery is blocked. `ce_out_n` stays 1 until the input returns high. `battery_warn_issued` pulses for one cycle at that edge, and the first and third accesses pass.
- R9: If `batt_low` is clear when recovery starts, no access after recovery is blocked and no warning pulse occurs.
- R10: `batt_sel` is 1 for battery B and 0 for battery A. With both batteries present it equals `batt_b_stronger`. With only one present it selects that one.
- R11: `backup_active` is 1 exactly when `batt_en` is 1 and `supply_below_batt` is 1.
- R12: When a supply failure and a chip-enable falling edge reach the block in the same cycle, the edge is handled as an access already under way. It passes, unless it is the access blocked for a warning, in which case it stays blocked until the input returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_in_n | input | 1 | Chip-enable from decoder, active low |
| supply_ok | input | 1 | Supply above trip point (asynchronous) |
| batt_a_present | input | 1 | Battery A attached |
| batt_b_present | input | 1 | Battery B attached |
| batt_b_stronger | input | 1 | Battery B stronger than A |
| supply_below_batt | input | 1 | Supply below selected battery |
| batt_low | input | 1 | Selected battery is weak |
| ce_out_n | output | 1 | Chip-enable to RAM, active low |
| batt_en | output | 1 | Battery connection enable |
| batt_sel | output | 1 | Battery select, 1 = B |
| backup_active | output | 1 | RAM fed from battery |
| write_protected | output | 1 | Access lock in force |
| battery_warn_issued | output | 1 | One-cycle pulse on the blocked warning access |

## Verification
A supply drop and a chip-enable falling edge can land in the same synchronized cycle. In that cycle the falling edge has to be treated as an access under way and not cut short. The bench drives both inputs on the same clock edge and checks that `ce_out_n` goes low and stays low, with `write_protected` still 0, until the input is released. It then repeats the case with a warning pending, where that same edge is the second access. Here `ce_out_n` must stay 1 while `battery_warn_issued` pulses, and the block must settle into protection once the input goes high.

// File: rtl/pfce_gate.sv
module pfce_gate #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int RECOV_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_in_n,
  input  logic supply_ok,
  input  logic batt_a_present,
  input  logic batt_b_present,
  input  logic batt_b_stronger,
  input  logic supply_below_batt,
  input  logic batt_low,
  output logic ce_out_n,
  output logic batt_en,
  output logic batt_sel,
  output logic backup_active,
  output logic write_protected,
  output logic battery_warn_issued
);

  localparam int RECOV_CYCLES = (CLK_HZ / 1_000_000) * RECOV_US;
  localparam int CW = $clog2(RECOV_CYCLES + 1);
  localparam int NS = 7;
  localparam logic [NS-1:0] SYNC_RST = 7'b100_0000;

  typedef enum logic [2:0] {ST_SEAL, ST_RUN, ST_DRAIN, ST_FAIL, ST_RECOV} st_t;

  st_t st;
  logic [NS-1:0] sy1, sy2;
  logic [CW-1:0] cnt;
  logic warn_pend, fall_seen, blk, armed;

  wire ce_s    = sy2[6];
  wire sup_s   = sy2[5];
  wire a_s     = sy2[4];
  wire b_s     = sy2[3];
  wire str_s   = sy2[2];
  wire below_s = sy2[1];
  wire low_s   = sy2[0];

  wire sealed   = (st == ST_SEAL);
  wire passing  = (st == ST_RUN) || (st == ST_DRAIN);
  wire fall     = (st == ST_RUN) && !ce_s && armed;
  wire warn_now = fall && warn_pend && fall_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= SYNC_RST;
      sy2 <= SYNC_RST;
    end else begin
      sy1 <= {ce_in_n, supply_ok, batt_a_present, batt_b_present,
              batt_b_stronger, supply_below_batt, batt_low};
      sy2 <= sy1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_SEAL;
      cnt       <= '0;
      warn_pend <= 1'b0;
      fall_seen <= 1'b0;
      blk       <= 1'b0;
      armed     <= 1'b1;
    end else begin
      armed <= (st != ST_RUN) || ce_s;
      blk   <= (warn_now || blk) && !ce_s;
      if (fall)     fall_seen <= 1'b1;
      if (warn_now) warn_pend <= 1'b0;
      case (st)
        ST_SEAL: if (sup_s) begin
          st        <= ST_RECOV;
          cnt       <= CW'(RECOV_CYCLES - 1);
          fall_seen <= 1'b0;
        end
        ST_RUN: if (!sup_s) st <= ce_s ? ST_FAIL : ST_DRAIN;
        ST_DRAIN: if (ce_s) st <= ST_FAIL;
        ST_FAIL: if (sup_s) begin
          st        <= ST_RECOV;
          cnt       <= CW'(RECOV_CYCLES - 1);
          warn_pend <= low_s;
          fall_seen <= 1'b0;
        end
        ST_RECOV: begin
          if (!sup_s)        st  <= ST_FAIL;
          else if (cnt == 0) st  <= ST_RUN;
          else               cnt <= cnt - 1'b1;
        end
        default: st <= ST_FAIL;
      endcase
    end
  end

  assign ce_out_n            = ce_s || blk || warn_now || !passing;
  assign write_protected     = !passing;
  assign battery_warn_issued = warn_now;
  assign batt_en             = !sealed && (a_s || b_s);
  assign batt_sel            = (a_s && b_s) ? str_s : b_s;
  assign backup_active       = batt_en && below_s;

endmodule

// File: rtl/pfce_gate_chk.sv
module pfce_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_out_n,
  input logic write_protected,
  input logic battery_warn_issued,
  input logic batt_en,
  input logic backup_active,
  input logic sealed,
  input logic sup_s
);

  a_r5_locked_high: assert property (@(posedge clk) disable iff (!rst_n)
    write_protected |-> ce_out_n);

  a_r2_sealed_no_batt: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |-> !batt_en);

  a_r2_unseal_on_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sealed) |-> $past(sup_s));

  a_r3_release_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(write_protected) |-> $past(sup_s));

  a_r8_warn_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    battery_warn_issued |-> ce_out_n);

  a_r8_warn_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    battery_warn_issued |=> !battery_warn_issued);

  a_r11_backup_needs_batt: assert property (@(posedge clk) disable iff (!rst_n)
    backup_active |-> batt_en);

endmodule

bind pfce_gate pfce_gate_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .ce_out_n(ce_out_n),
  .write_protected(write_protected),
  .battery_warn_issued(battery_warn_issued),
  .batt_en(batt_en),
  .backup_active(backup_active),
  .sealed(sealed),
  .sup_s(sup_s)
);

// File: tb/pfce_gate_tb_top.sv
module pfce_gate_tb_top;
  localparam int HZ = 50_000_000;
  localparam int US = 1;
  localparam int N  = (HZ / 1_000_000) * US;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 1'b1, sup = 1'b0, ba = 1'b1, bb = 1'b0, str = 1'b0, below = 1'b1, low = 1'b0;
  logic ce_out_n, batt_en, batt_sel, backup_active, write_protected, warn;
  int total = 0, fails = 0, wcnt = 0;

  always #10 clk = ~clk;

  pfce_gate #(.CLK_HZ(HZ), .RECOV_US(US)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_in_n(ce), .supply_ok(sup),
    .batt_a_present(ba), .batt_b_present(bb), .batt_b_stronger(str),
    .supply_below_batt(below), .batt_low(low),
    .ce_out_n(ce_out_n), .batt_en(batt_en), .batt_sel(batt_sel),
    .backup_active(backup_active), .write_protected(write_protected),
    .battery_warn_issued(warn));

  always @(posedge clk) if (rst_n && warn) wcnt++;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input string req, input logic exp_out, input logic exp_warn);
    ce = 1'b0; step(2);
    chk(req, ce_out_n, exp_out);
    chk(req, warn, exp_warn);
    ce = 1'b1; step(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 out", ce_out_n, 1);
    chk("R1 wp", write_protected, 1);
    chk("R2 en", batt_en, 0);
    bb = 1'b1; step(3);
    chk("R2 sealed en", batt_en, 0);
    chk("R11 sealed", backup_active, 0);
    ce = 1'b0; step(3);
    chk("R1 blocked", ce_out_n, 1);
    ce = 1'b1;

    sup = 1'b1; k = 0;
    while (write_protected && k < 1000) begin step(1); k++; end
    chk("R3 recovery edges", k, N + 3);
    chk("R2 unsealed en", batt_en, 1);

    for (int i = 0; i < 12; i++) begin
      ce = ((i * 5) % 3 == 0); step(2);
      chk("R4 pass", ce_out_n, ce);
    end
    ce = 1'b1; step(2);

    for (int v = 0; v < 16; v++) begin
      ba = v[0]; bb = v[1]; str = v[2]; below = v[3]; step(3);
      chk("R10 sel", batt_sel, (v[0] && v[1]) ? v[2] : v[1]);
      chk("R2 en", batt_en, v[0] | v[1]);
      chk("R11 backup", backup_active, (v[0] | v[1]) & v[3]);
    end
    ba = 1'b1; bb = 1'b0; str = 1'b0; below = 1'b0; step(3);

    sup = 1'b0; step(3);
    chk("R5 wp", write_protected, 1);
    chk("R5 out", ce_out_n, 1);
    ce = 1'b0; step(3);
    chk("R5 held", ce_out_n, 1);
    ce = 1'b1;

    sup = 1'b1; step(8);
    chk("R7 in recovery", write_protected, 1);
    sup = 1'b0; step(N + 10);
    chk("R7 abandoned", write_protected, 1);

    low = 1'b1; step(3);
    sup = 1'b1; step(3); low = 1'b0; step(N);
    chk("R3 released", write_protected, 0);
    access("R8 first", 0, 0);
    ce = 1'b0; step(2);
    chk("R8 second out", ce_out_n, 1);
    chk("R8 pulse", warn, 1);
    step(1);
    chk("R8 pulse ends", warn, 0);
    chk("R8 still blocked", ce_out_n, 1);
    ce = 1'b1; step(2);
    access("R8 third", 0, 0);
    chk("R8 pulse count", wcnt, 1);

    sup = 1'b0; step(4);
    sup = 1'b1; step(3 + N);
    access("R9 first", 0, 0);
    access("R9 second", 0, 0);
    access("R9 third", 0, 0);
    chk("R9 no pulse", wcnt, 1);

    ce = 1'b0; step(2);
    sup = 1'b0; step(4);
    chk("R6 access kept", ce_out_n, 0);
    chk("R6 not yet locked", write_protected, 0);
    ce = 1'b1; step(3);
    chk("R6 locked", write_protected, 1);
    ce = 1'b0; step(3);
    chk("R6 held", ce_out_n, 1);
    ce = 1'b1; step(2);

    sup = 1'b1; step(3 + N);
    ce = 1'b0; sup = 1'b0; step(2);
    chk("R12 edge passes", ce_out_n, 0);
    step(3);
    chk("R12 still passing", ce_out_n, 0);
    chk("R12 wp", write_protected, 0);
    ce = 1'b1; step(3);
    chk("R12 locked", write_protected, 1);
    ce = 1'b0; step(3);
    chk("R12 held", ce_out_n, 1);
    ce = 1'b1;

    low = 1'b1; step(3);
    sup = 1'b1; step(3 + N); low = 1'b0;
    access("R12 warn first", 0, 0);
    ce = 1'b0; sup = 1'b0; step(2);
    chk("R12 warn blocked", ce_out_n, 1);
    chk("R12 warn pulse", warn, 1);
    step(3);
    chk("R12 warn held", ce_out_n, 1);
    chk("R12 warn wp", write_protected, 0);
    ce = 1'b1; step(3);
    chk("R12 warn locked", write_protected, 1);
    chk("R12 pulse count", wcnt, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule